// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits in front of one bus slave port and decides, for every access presented to it, whether the access may proceed. It holds a small table of programmable address regions. Each region has an inclusive address window at 32-byte granularity, a valid flag, an optional process-identifier match and a permission word. That word has a field for each of eight requesting masters. Masters 0 to 3 carry a full privilege-aware rights field. Masters 4 to 7 carry only a read enable and a write enable.

An access is described by its address, the number of the requesting master, its privilege level, its kind (read, write or instruction fetch) and a process identifier. One clock later the block returns a grant bit and a vector with one bit per region that matched the access. A simple write port loads the descriptors one word at a time. The write port records which master issued the write, so that the core (master 0) cannot take away the bounds of region 0 or the debugger's (master 1) rights in it. After reset, region 0 covers the full 4 GB space with every right for every master, so the system can boot before software sets up the table.

Top module: `region_guard`

## Requirements
- R1: A request with `acc_valid` high is answered in the next cycle with `res_valid` high. In a cycle after no request, `res_valid`, `res_grant` and `res_hit` are all zero.
- R2: Region i sets `res_hit[i]` only when `acc_addr[31:5]` lies between the stored start `[31:5]` and end `[31:5]`, both ends included. Written start bits 4:0 act as zeros and end bits 4:0 act as ones. `cfg_sel` selects the word written: 0 start, 1 end, 2 permission word, 3 attribute word.
- R3: Attribute bit 0 is the region valid flag. A region whose flag is clear never hits.
- R4: For master m in 0..3, permission bits m*6+2..m*6 form the user rights: bit m*6+2 read, m*6+1 write, m*6 execute. With `acc_super`=0 these rights alone decide. `acc_kind` 0 is read, 1 is write, 2 is instruction fetch, and 3 is never permitted.
- R5: For master m in 0..3, permission bits m*6+4..m*6+3 give the supervisor rights used when `acc_super`=1: 0 read/write/execute, 1 read/execute, 2 read/write, 3 same as the user rights.
- R6: For master m in 4..7, permission bit 24+(m-4)*2 enables writes and bit 25+(m-4)*2 enables reads. A fetch needs the read enable. Privilege level has no effect for these masters.
- R7: With protection on, an access is granted exactly when at least one hitting region permits it, so overlapping regions combine their rights by OR.
- R8: With `prot_enable` low, every access is granted, and `res_hit` still reports the matching regions.
- R9: If bit m*6+5 is set for an access from master m in 0..3, the region hits only if `acc_pid` equals the region identifier (attribute bits 15:8) on every bit that is clear in the region mask (attribute bits 23:16).
- R10: Writes by master 0 to region 0 leave its start and end unchanged and keep permission bits 11:6 (the debugger's field and its identifier enable) unchanged. The other permission bits still take the written value. Other masters may write every region 0 word.
- R11: After reset, region 0 is valid, spans 0x00000000 to 0xFFFFFFFF and grants every right to every master with identifier checks off. All other regions are invalid.
- R12: `region_count_code` reports the implemented region count: 0 for 8, 1 for 12, 2 for 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_enable | input | 1 | Global protection enable; low grants all accesses |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_master | input | 3 | Master issuing the descriptor write |
| cfg_region | input | RIDX_W | Region index written |
| cfg_sel | input | 2 | Descriptor word: 0 start, 1 end, 2 permissions, 3 attributes |
| cfg_wdata | input | 32 | Descriptor write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access byte address |
| acc_master | input | 3 | Requesting master number |
| acc_super | input | 1 | 1 for supervisor, 0 for user |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_pid | input | 8 | Process identifier of the access |
| res_valid | output | 1 | Result present (one cycle after the request) |
| res_grant | output | 1 | Access allowed |
| res_hit | output | NUM_REGIONS | Regions matching the access |
| region_count_code | output | 2 | Encoded number of implemented regions |

## Verification
The bench builds the block with its default of 8 regions. That keeps the hit vector at one byte and keeps a descriptor rewrite at two cycles, so full sweeps fit easily. For every 5-bit rights code at each of the four full-field masters, it issues accesses from all eight masters at both privilege levels and with all four access kinds. It also walks every read/write code for each of the upper masters and all 256 process identifiers against one identifier and mask pair. Region-0 locking, inclusive 32-byte bounds, overlap, the valid flag and the global bypass are each driven through short directed sequences. All of these are checked against an arithmetic model of the table.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  localparam int ADDR_W      = 32;
  localparam int GRAN_BITS   = 5;
  localparam int PID_W       = 8;
  localparam int PERM_W      = 32;
  localparam int MASTER_W    = 3;
  localparam int LOW_FIELD_W = 6;
  localparam int HIGH_BASE   = 24;
  localparam int CORE_ID     = 0;
  localparam int DEBUG_ID    = 1;
  localparam int PAGE_W      = ADDR_W - GRAN_BITS;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_PERM  = 2'd2,
    SEL_ATTR  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              valid;
    logic [PID_W-1:0]  pid;
    logic [PID_W-1:0]  pid_mask;
    logic [PERM_W-1:0] perm;
    logic [PAGE_W-1:0] lo;
    logic [PAGE_W-1:0] hi;
  } region_t;

  // Every right for every master, identifier checks off.
  function automatic logic [PERM_W-1:0] open_perm();
    logic [PERM_W-1:0] p;
    p = '0;
    for (int m = 0; m < 4; m++) p[m*LOW_FIELD_W +: 5] = 5'h1F;
    p[PERM_W-1:HIGH_BASE] = '1;
    return p;
  endfunction

  // Bits of the debugger's field (rights plus identifier enable).
  function automatic logic [PERM_W-1:0] debug_field();
    logic [PERM_W-1:0] p;
    p = '0;
    p[DEBUG_ID*LOW_FIELD_W +: LOW_FIELD_W] = '1;
    return p;
  endfunction

  // Decide whether a permission word lets this master perform this kind.
  function automatic logic rights_allow(input logic [PERM_W-1:0] perm,
                                        input logic [MASTER_W-1:0] master,
                                        input logic sup,
                                        input logic [1:0] kind);
    logic [4:0] fld;
    logic [1:0] hb;
    logic [2:0] rwx;
    int off;
    fld = '0;
    hb  = '0;
    rwx = '0;
    off = 0;
    if (!master[2]) begin
      off = int'(master[1:0]) * LOW_FIELD_W;
      fld = perm[off +: 5];
      if (!sup) begin
        rwx = fld[2:0];
      end else begin
        case (fld[4:3])
          2'd0:    rwx = 3'b111;
          2'd1:    rwx = 3'b101;
          2'd2:    rwx = 3'b110;
          default: rwx = fld[2:0];
        endcase
      end
    end else begin
      off = HIGH_BASE + int'(master[1:0]) * 2;
      hb  = perm[off +: 2];
      rwx = {hb[1], hb[0], hb[1]};
    end
    case (kind)
      KIND_READ:  return rwx[2];
      KIND_WRITE: return rwx[1];
      KIND_FETCH: return rwx[0];
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/region_guard_table.sv
module region_guard_table
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RIDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [MASTER_W-1:0] cfg_master,
  input  logic [RIDX_W-1:0]   cfg_region,
  input  logic [1:0]          cfg_sel,
  input  logic [PERM_W-1:0]   cfg_wdata,
  output region_t             regions_o [NUM_REGIONS]
);

  localparam logic [PERM_W-1:0] DBG_MASK  = debug_field();
  localparam logic [PERM_W-1:0] OPEN_PERM = open_perm();

  region_t regions_q [NUM_REGIONS];

  logic in_range;
  logic core_lock;
  logic unused_bits;

  assign in_range    = int'(cfg_region) < NUM_REGIONS;
  assign core_lock   = (cfg_master == MASTER_W'(CORE_ID)) && (cfg_region == '0);
  assign unused_bits = ^{cfg_wdata[GRAN_BITS-1:0], cfg_wdata[7:1], cfg_wdata[31:24]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGIONS; i++) regions_q[i] <= '0;
      regions_q[0].valid <= 1'b1;
      regions_q[0].hi    <= '1;
      regions_q[0].perm  <= OPEN_PERM;
    end else if (cfg_we && in_range) begin
      case (cfg_sel)
        SEL_START: if (!core_lock) regions_q[cfg_region].lo <= cfg_wdata[ADDR_W-1:GRAN_BITS];
        SEL_END:   if (!core_lock) regions_q[cfg_region].hi <= cfg_wdata[ADDR_W-1:GRAN_BITS];
        SEL_PERM: begin
          if (core_lock)
            regions_q[cfg_region].perm <= (cfg_wdata & ~DBG_MASK) |
                                          (regions_q[cfg_region].perm & DBG_MASK);
          else
            regions_q[cfg_region].perm <= cfg_wdata;
        end
        default: begin
          regions_q[cfg_region].valid    <= cfg_wdata[0];
          regions_q[cfg_region].pid      <= cfg_wdata[15:8];
          regions_q[cfg_region].pid_mask <= cfg_wdata[23:16];
        end
      endcase
    end
  end

  assign regions_o = regions_q;

  // R10: core writes cannot move region 0 bounds.
  a_r10_bounds_locked: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_master == MASTER_W'(CORE_ID) && cfg_region == '0 &&
     (cfg_sel == SEL_START || cfg_sel == SEL_END))
    |=> ($stable(regions_q[0].lo) && $stable(regions_q[0].hi)));

  // R10: core writes cannot change the debugger's field in region 0.
  a_r10_debug_field_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_master == MASTER_W'(CORE_ID) && cfg_region == '0 && cfg_sel == SEL_PERM)
    |=> $stable(regions_q[0].perm[11:6]));

endmodule

// File: rtl/region_guard_match.sv
module region_guard_match
  import region_guard_pkg::*;
(
  input  region_t             rgn,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [MASTER_W-1:0] acc_master,
  input  logic                acc_super,
  input  logic [1:0]          acc_kind,
  input  logic [PID_W-1:0]    acc_pid,
  output logic                hit,
  output logic                permit
);

  logic [PAGE_W-1:0] page;
  logic              addr_ok;
  logic              pid_en;
  logic              pid_ok;
  logic              unused_low;
  int                pid_bit;

  assign page       = acc_addr[ADDR_W-1:GRAN_BITS];
  assign unused_low = ^acc_addr[GRAN_BITS-1:0];
  assign addr_ok    = (page >= rgn.lo) && (page <= rgn.hi);

  always_comb begin
    pid_bit = int'(acc_master[1:0]) * LOW_FIELD_W + 5;
    pid_en  = !acc_master[2] && rgn.perm[pid_bit];
    pid_ok  = !pid_en || (((acc_pid ^ rgn.pid) & ~rgn.pid_mask) == '0);
  end

  assign hit    = rgn.valid && addr_ok && pid_ok;
  assign permit = hit && rights_allow(rgn.perm, acc_master, acc_super, acc_kind);

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RIDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   prot_enable,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_master,
  input  logic [RIDX_W-1:0]      cfg_region,
  input  logic [1:0]             cfg_sel,
  input  logic [31:0]            cfg_wdata,
  input  logic                   acc_valid,
  input  logic [31:0]            acc_addr,
  input  logic [2:0]             acc_master,
  input  logic                   acc_super,
  input  logic [1:0]             acc_kind,
  input  logic [7:0]             acc_pid,
  output logic                   res_valid,
  output logic                   res_grant,
  output logic [NUM_REGIONS-1:0] res_hit,
  output logic [1:0]             region_count_code
);

  localparam logic [1:0] COUNT_CODE = (NUM_REGIONS <= 8)  ? 2'd0 :
                                      (NUM_REGIONS <= 12) ? 2'd1 : 2'd2;

  region_t                rgn [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_c;
  logic [NUM_REGIONS-1:0] permit_c;
  logic                   grant_c;

  region_guard_table #(.NUM_REGIONS(NUM_REGIONS)) u_table (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_master (cfg_master),
    .cfg_region (cfg_region),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .regions_o  (rgn)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    region_guard_match u_match (
      .rgn        (rgn[g]),
      .acc_addr   (acc_addr),
      .acc_master (acc_master),
      .acc_super  (acc_super),
      .acc_kind   (acc_kind),
      .acc_pid    (acc_pid),
      .hit        (hit_c[g]),
      .permit     (permit_c[g])
    );
  end

  assign grant_c = !prot_enable || (|permit_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_hit   <= '0;
    end else begin
      res_valid <= acc_valid;
      res_grant <= acc_valid && grant_c;
      res_hit   <= acc_valid ? hit_c : '0;
    end
  end

  assign region_count_code = COUNT_CODE;

  // R1: a request produces a result one cycle later.
  a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  // R1: no request means quiet outputs in the next cycle.
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && !res_grant && res_hit == '0));

  // R8: protection off grants everything.
  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !prot_enable) |=> res_grant);

  // R7: with protection on, a grant needs at least one hitting region.
  a_r7_grant_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && prot_enable) |=> (!res_grant || res_hit != '0));

endmodule

// File: tb/region_guard_tb.sv
`timescale 1ns/1ps
module region_guard_tb;

  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_master = '0;
  logic [2:0]    cfg_region = '0;
  logic [1:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [31:0]   acc_addr = '0;
  logic [2:0]    acc_master = '0;
  logic          acc_super = 1'b0;
  logic [1:0]    acc_kind = '0;
  logic [7:0]    acc_pid = '0;
  logic          res_valid;
  logic          res_grant;
  logic [NR-1:0] res_hit;
  logic [1:0]    region_count_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench record of the table, updated by the write rules of R10/R11.
  logic [26:0] m_lo [NR];
  logic [26:0] m_hi [NR];
  logic [31:0] m_perm [NR];
  logic        m_val [NR];
  logic [7:0]  m_pid [NR];
  logic [7:0]  m_msk [NR];

  always #10 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR)) u_dut (
    .clk(clk), .rst(rst), .prot_enable(en),
    .cfg_we(cfg_we), .cfg_master(cfg_master), .cfg_region(cfg_region),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_master(acc_master),
    .acc_super(acc_super), .acc_kind(acc_kind), .acc_pid(acc_pid),
    .res_valid(res_valid), .res_grant(res_grant), .res_hit(res_hit),
    .region_count_code(region_count_code)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_lo[r] = '0; m_hi[r] = '0; m_perm[r] = '0; m_val[r] = 0; m_pid[r] = '0; m_msk[r] = '0;
    end
    m_val[0]  = 1;
    m_hi[0]   = '1;
    m_perm[0] = 32'hFF7DF7DF;
  endtask

  function automatic void model_eval(input logic [31:0] a, input int m, input bit s,
                                     input int k, input logic [7:0] p,
                                     output logic [NR-1:0] h, output logic g);
    logic rd, wr, ex, al, pe, pok;
    logic [2:0] u;
    logic [1:0] sf;
    h = '0;
    g = 0;
    for (int r = 0; r < NR; r++) begin
      pe  = (m < 4) && m_perm[r][m*6+5];
      pok = !pe || (((p ^ m_pid[r]) & ~m_msk[r]) == 8'h00);
      h[r] = m_val[r] && (a[31:5] >= m_lo[r]) && (a[31:5] <= m_hi[r]) && pok;
      if (m < 4) begin
        u  = m_perm[r][m*6 +: 3];
        sf = m_perm[r][m*6+3 +: 2];
        if (!s || sf == 2'd3) begin rd = u[2]; wr = u[1]; ex = u[0]; end
        else if (sf == 2'd0) begin rd = 1; wr = 1; ex = 1; end
        else if (sf == 2'd1) begin rd = 1; wr = 0; ex = 1; end
        else begin rd = 1; wr = 1; ex = 0; end
      end else begin
        wr = m_perm[r][24+(m-4)*2];
        rd = m_perm[r][25+(m-4)*2];
        ex = rd;
      end
      al = (k == 0) ? rd : (k == 1) ? wr : (k == 2) ? ex : 1'b0;
      if (h[r] && al) g = 1;
    end
    if (!en) g = 1;
  endfunction

  task automatic cfg_write(input int wm, input int r, input int sel, input logic [31:0] d);
    bit lock;
    @(negedge clk);
    cfg_we = 1; cfg_master = wm[2:0]; cfg_region = r[2:0]; cfg_sel = sel[1:0]; cfg_wdata = d;
    lock = (wm == 0) && (r == 0);
    case (sel)
      0: if (!lock) m_lo[r] = d[31:5];
      1: if (!lock) m_hi[r] = d[31:5];
      2: m_perm[r] = lock ? ((d & ~32'h00000FC0) | (m_perm[r] & 32'h00000FC0)) : d;
      default: begin m_val[r] = d[0]; m_pid[r] = d[15:8]; m_msk[r] = d[23:16]; end
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input int m, input bit s,
                        input int k, input logic [7:0] p);
    logic [NR-1:0] h;
    logic g;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_master = m[2:0]; acc_super = s; acc_kind = k[1:0]; acc_pid = p;
    @(negedge clk);
    model_eval(a, m, s, k, p, h, g);
    check(tag, {22'h0, res_valid, res_hit, res_grant}, {22'h0, 1'b1, h, g});
    acc_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: quiet outputs with no request; R12 count code for 8 regions.
    check("R1", {res_valid, res_grant, 8'(res_hit)}, 10'h0);
    check("R12", 32'(region_count_code), 32'd0);

    // R11: reset table opens everything through region 0.
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 3; k++)
          access("R11", 32'h0123_4567 * (m + 1) + 32'(k), m, s[0], k, 8'h00);
    @(negedge clk);
    check("R1", {res_valid, res_grant, 8'(res_hit)}, 10'h0);

    // R10: core cannot move region 0 or drop the debugger's rights.
    cfg_write(0, 0, 0, 32'h0000_1000);
    cfg_write(0, 0, 1, 32'h0000_1FFF);
    access("R10", 32'h0000_0000, 1, 0, 0, 8'h00);
    access("R10", 32'h8000_0000, 2, 0, 1, 8'h00);
    cfg_write(0, 0, 2, 32'h0000_0000);
    for (int m = 0; m < 8; m++) access("R10", 32'h0000_4000, m, 0, 0, 8'h00);
    access("R10", 32'h0000_4000, 1, 1, 1, 8'h00);
    cfg_write(1, 0, 2, 32'h0000_0000);
    cfg_write(1, 0, 0, 32'h0000_1000);
    access("R10", 32'h0000_0800, 1, 0, 0, 8'h00);
    access("R10", 32'h0000_1000, 1, 0, 0, 8'h00);

    // R3: invalid region 0 no longer hits.
    cfg_write(1, 0, 3, 32'h0000_0000);
    access("R3", 32'h0000_1000, 1, 0, 0, 8'h00);

    // R2: 32-byte granular inclusive bounds.
    cfg_write(2, 3, 0, 32'h0000_4013);
    cfg_write(2, 3, 1, 32'h0000_4FE0);
    cfg_write(2, 3, 2, 32'h0000_0007);
    cfg_write(2, 3, 3, 32'h0000_0001);
    access("R2", 32'h0000_3FFF, 0, 0, 0, 8'h00);
    access("R2", 32'h0000_4000, 0, 0, 0, 8'h00);
    access("R2", 32'h0000_401F, 0, 0, 0, 8'h00);
    access("R2", 32'h0000_4FFF, 0, 0, 0, 8'h00);
    access("R2", 32'h0000_5000, 0, 0, 0, 8'h00);
    cfg_write(2, 3, 3, 32'h0000_0000);
    access("R3", 32'h0000_4000, 0, 0, 0, 8'h00);

    // R4/R5: every low-master rights code, all requesters, levels and kinds.
    cfg_write(2, 2, 0, 32'h0000_2000);
    cfg_write(2, 2, 1, 32'h0000_2FFF);
    cfg_write(2, 2, 3, 32'h0000_0001);
    for (int f = 0; f < 32; f++)
      for (int wm = 0; wm < 4; wm++) begin
        cfg_write(2, 2, 2, 32'(f) << (wm * 6));
        for (int am = 0; am < 8; am++)
          for (int k = 0; k < 4; k++) begin
            access("R4", 32'h0000_2400, am, 0, k, 8'h00);
            access("R5", 32'h0000_2400, am, 1, k, 8'h00);
          end
      end

    // R6: every high-master read/write code.
    for (int v = 0; v < 4; v++)
      for (int hm = 4; hm < 8; hm++) begin
        cfg_write(2, 2, 2, 32'(v) << (24 + (hm - 4) * 2));
        for (int am = 0; am < 8; am++)
          for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++)
              access("R6", 32'h0000_2FFF, am, s[0], k, 8'h00);
      end

    // R9: identifier 0xA5 under mask 0x0F for master 2.
    cfg_write(2, 2, 2, (32'h07 << 12) | (32'h1 << 17));
    cfg_write(2, 2, 3, 32'h000F_A501);
    for (int p = 0; p < 256; p++) begin
      access("R9", 32'h0000_2000, 2, 0, 0, 8'(p));
      if (p % 16 == 0) access("R9", 32'h0000_2000, 0, 0, 0, 8'(p));
    end
    cfg_write(2, 2, 3, 32'h0000_0000);

    // R7: overlapping regions OR their rights.
    cfg_write(2, 4, 0, 32'h0000_6000);
    cfg_write(2, 4, 1, 32'h0000_6FFF);
    cfg_write(2, 4, 2, 32'h0000_4000);
    cfg_write(2, 4, 3, 32'h0000_0001);
    cfg_write(2, 5, 0, 32'h0000_6800);
    cfg_write(2, 5, 1, 32'h0000_7FFF);
    cfg_write(2, 5, 2, 32'h0000_2000);
    cfg_write(2, 5, 3, 32'h0000_0001);
    for (int k = 0; k < 4; k++) begin
      access("R7", 32'h0000_6100, 2, 0, k, 8'h00);
      access("R7", 32'h0000_6900, 2, 0, k, 8'h00);
      access("R7", 32'h0000_7000, 2, 0, k, 8'h00);
      access("R7", 32'h0000_6900, 3, 0, k, 8'h00);
    end

    // R8: protection off grants all, hits still reported.
    en = 0;
    for (int m = 0; m < 8; m++) begin
      access("R8", 32'h0000_9000, m, 0, 1, 8'h00);
      access("R8", 32'h0000_6900, m, 1, 3, 8'h00);
    end
    en = 1;
    access("R8", 32'h0000_9000, 0, 0, 0, 8'h00);

    summary();
  end

endmodule